// File: doc/BRIEF.md
# PCI Target Claim and Data-Phase Sequencer

This block is the target-side control path of a 32-bit PCI agent. It watches for the start of a bus transaction. That start is the first clock at which FRAME# is sampled low after being sampled high. At that clock it classifies the command on C/BE# and compares the address against a set of base-address regions, or checks IDSEL for a configuration access. If one of the device's spaces is hit, the block claims the transaction with medium DEVSEL# timing. It then keeps TRDY# asserted so that each data phase completes whenever the initiator asserts IRDY#.

A queue that absorbs posted memory writes reports when it cannot take more data. In that case the block stops a memory write with a retry or disconnect on STOP#. At the end of a transaction it parks its three response lines high for one clock before releasing them. Each PCI response signal is split into an output value and an active-low output enable, which suits a pad ring that builds the bidirectional pins. A one-hot select bus tells the rest of the device which region matched, and a separate flag marks a configuration access.

Top module: `pci_tgt_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it rises until a claim, all six response outputs (`devsel_out_n`, `devsel_oe_n`, `trdy_out_n`, `trdy_oe_n`, `stop_out_n`, `stop_oe_n`) are 1, `cs_sel` is all zero and `cfg_sel` is 0.
- R2: Command codes on `cbe_in_n` fall into these classes. I/O is 0010 and 0011. Memory read is 0110, 1100 and 1110. Memory write is 0111 and 1111. Configuration is 1010 and 1011. Every other code, including the reserved 0100, 0101, 1000 and 1001, is never claimed.
- R3: Region i hits when `((ad_in ^ base_i) & mask_i) == 0` and its type matches the command class. The type is I/O when `bar_is_io[i]` is 1 and memory otherwise. An I/O region also needs `cmd_io_en` high, and a memory region needs `cmd_mem_en` high. A hit on any region causes a claim.
- R4: If several regions hit, only the lowest index is reported. From the clock after the address phase until the response enables are released, `cs_sel` holds exactly that one bit. At all other times it is zero.
- R5: A configuration command with `idsel_in` high is claimed whatever the address or enables are. `cfg_sel` is then held over the same window as in R4, with `cs_sel` zero. A configuration command with `idsel_in` low is not claimed.
- R6: Let A be the address-phase edge. For a claimed transaction, `devsel_out_n` and all three enables go low after edge A+1, which is medium timing. After edge A they are still released.
- R7: Unless R9 applies, `trdy_out_n` goes low together with `devsel_out_n` and stays low. A data phase completes at every edge where `irdy_in_n` and `trdy_out_n` are both low.
- R8: If a data phase completes at an edge where `frame_in_n` is high, the next clock drives DEVSEL#, TRDY# and STOP# high with their enables low. The clock after that releases the enables.
- R9: For a memory write, the queue-full flag `wq_full` forces a stop. This happens when the flag is sampled high at edge A+1, or at any later edge while TRDY# is low that is not a final completion. After that edge, `stop_out_n` and `devsel_out_n` are low and `trdy_out_n` is high. This holds until `frame_in_n` is sampled high, and then the release of R8 follows.
- R10: `wq_full` has no effect on memory reads, I/O accesses or configuration accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_in_n | input | 1 | FRAME# as seen on the bus |
| irdy_in_n | input | 1 | IRDY# as seen on the bus |
| idsel_in | input | 1 | Configuration select for this device |
| ad_in | input | ADDR_W (32) | Address/data bus input |
| cbe_in_n | input | 4 | Command / byte-enable input |
| bar_base | input | NUM_BAR*ADDR_W (192) | Region base addresses, region i at slice i |
| bar_mask | input | NUM_BAR*ADDR_W (192) | Region compare masks, 1 = bit compared |
| bar_is_io | input | NUM_BAR (6) | Region type, 1 = I/O, 0 = memory |
| cmd_io_en | input | 1 | I/O space response enable |
| cmd_mem_en | input | 1 | Memory space response enable |
| wq_full | input | 1 | Posted-write queue cannot accept more data |
| devsel_out_n | output | 1 | DEVSEL# output value |
| devsel_oe_n | output | 1 | DEVSEL# output enable, active low |
| trdy_out_n | output | 1 | TRDY# output value |
| trdy_oe_n | output | 1 | TRDY# output enable, active low |
| stop_out_n | output | 1 | STOP# output value |
| stop_oe_n | output | 1 | STOP# output enable, active low |
| cs_sel | output | NUM_BAR (6) | One-hot matched region |
| cfg_sel | output | 1 | Configuration access claimed |

## Verification
The response pins are all decoded from one state register. A wrong state therefore shows up at the ports in the very next clock. It appears either as DEVSEL# and TRDY# out of step with the medium-timing window, or as STOP# and TRDY# low together, or as enables that drop without the one-clock high park. A wrong captured decode shows up for the whole transaction: `cs_sel` is not one-hot, names the wrong region, or stays non-zero once the enables are released. A lost write-type flag shows up as a burst that runs on through a full queue instead of stopping after the next edge.

// File: rtl/pci_tgt_pkg.sv
package pci_tgt_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WAIT,
      ST_DATA,
      ST_STOP,
      ST_TURN
   } tgt_state_e;

   typedef enum logic [1:0] {
      SP_NONE,
      SP_IO,
      SP_MEM,
      SP_CFG
   } space_e;

   typedef struct packed {
      space_e space;
      logic   is_write;
   } cmd_info_t;

   // Command classification, R2
   function automatic cmd_info_t classify_cmd(input logic [3:0] cbe_n);
      cmd_info_t info;
      info.space    = SP_NONE;
      info.is_write = 1'b0;
      case (cbe_n)
         4'b0010: info.space = SP_IO;
         4'b0011: begin info.space = SP_IO;  info.is_write = 1'b1; end
         4'b0110,
         4'b1100,
         4'b1110: info.space = SP_MEM;
         4'b0111,
         4'b1111: begin info.space = SP_MEM; info.is_write = 1'b1; end
         4'b1010: info.space = SP_CFG;
         4'b1011: begin info.space = SP_CFG; info.is_write = 1'b1; end
         default: info.space = SP_NONE;
      endcase
      return info;
   endfunction

endpackage

// File: rtl/pci_tgt_decode.sv
module pci_tgt_decode
   import pci_tgt_pkg::*;
#(
   parameter int NUM_BAR = 6,
   parameter int ADDR_W  = 32
) (
   input  logic [ADDR_W-1:0]         ad,
   input  logic [3:0]                cbe_n,
   input  logic                      idsel,
   input  logic [NUM_BAR*ADDR_W-1:0] bar_base,
   input  logic [NUM_BAR*ADDR_W-1:0] bar_mask,
   input  logic [NUM_BAR-1:0]        bar_is_io,
   input  logic                      io_en,
   input  logic                      mem_en,
   output logic                      claim,
   output logic [NUM_BAR-1:0]        cs_hit,
   output logic                      cfg_hit,
   output logic                      post_wr
);

   cmd_info_t          info;
   logic [NUM_BAR-1:0] raw_hit;
   logic               io_ok;
   logic               mem_ok;

   assign info   = classify_cmd(cbe_n);
   assign io_ok  = (info.space == SP_IO)  && io_en;
   assign mem_ok = (info.space == SP_MEM) && mem_en;

   for (genvar i = 0; i < NUM_BAR; i++) begin : g_bar
      logic addr_eq;
      assign addr_eq    = ((ad ^ bar_base[i*ADDR_W +: ADDR_W]) & bar_mask[i*ADDR_W +: ADDR_W]) == '0;
      assign raw_hit[i] = addr_eq && (bar_is_io[i] ? io_ok : mem_ok);
   end

   // keep only the lowest matching region
   assign cs_hit  = raw_hit & (~raw_hit + NUM_BAR'(1));
   assign cfg_hit = (info.space == SP_CFG) && idsel;
   assign claim   = (|raw_hit) || cfg_hit;
   assign post_wr = (info.space == SP_MEM) && info.is_write;

endmodule

// File: rtl/pci_tgt_seq.sv
module pci_tgt_seq
   import pci_tgt_pkg::*;
#(
   parameter int NUM_BAR = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               frame_in_n,
   input  logic               irdy_in_n,
   input  logic               wq_full,
   input  logic               claim,
   input  logic [NUM_BAR-1:0] cs_hit,
   input  logic               cfg_hit,
   input  logic               post_wr,
   output tgt_state_e         state,
   output logic [NUM_BAR-1:0] cs_sel,
   output logic               cfg_sel
);

   tgt_state_e         state_nx;
   logic               frame_q;
   logic               pw_q;
   logic               addr_phase;
   logic               must_stop;

   assign addr_phase = !frame_in_n && frame_q;
   assign must_stop  = pw_q && wq_full;

   always_comb begin
      state_nx = state;
      case (state)
         ST_IDLE: if (addr_phase && claim) state_nx = ST_WAIT;
         ST_WAIT: state_nx = must_stop ? ST_STOP : ST_DATA;
         ST_DATA: begin
            if (!irdy_in_n && frame_in_n) state_nx = ST_TURN;
            else if (must_stop)           state_nx = ST_STOP;
         end
         ST_STOP: if (frame_in_n) state_nx = ST_TURN;
         ST_TURN: state_nx = ST_IDLE;
         default: state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         frame_q <= 1'b1;
         pw_q    <= 1'b0;
         cs_sel  <= '0;
         cfg_sel <= 1'b0;
      end else begin
         state   <= state_nx;
         frame_q <= frame_in_n;
         if (state == ST_IDLE && state_nx == ST_WAIT) begin
            pw_q    <= post_wr;
            cs_sel  <= cs_hit;
            cfg_sel <= cfg_hit;
         end else if (state == ST_TURN) begin
            pw_q    <= 1'b0;
            cs_sel  <= '0;
            cfg_sel <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/pci_tgt_ctrl.sv
module pci_tgt_ctrl
   import pci_tgt_pkg::*;
#(
   parameter int NUM_BAR = 6,
   parameter int ADDR_W  = 32
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      frame_in_n,
   input  logic                      irdy_in_n,
   input  logic                      idsel_in,
   input  logic [ADDR_W-1:0]         ad_in,
   input  logic [3:0]                cbe_in_n,
   input  logic [NUM_BAR*ADDR_W-1:0] bar_base,
   input  logic [NUM_BAR*ADDR_W-1:0] bar_mask,
   input  logic [NUM_BAR-1:0]        bar_is_io,
   input  logic                      cmd_io_en,
   input  logic                      cmd_mem_en,
   input  logic                      wq_full,
   output logic                      devsel_out_n,
   output logic                      devsel_oe_n,
   output logic                      trdy_out_n,
   output logic                      trdy_oe_n,
   output logic                      stop_out_n,
   output logic                      stop_oe_n,
   output logic [NUM_BAR-1:0]        cs_sel,
   output logic                      cfg_sel
);

   if (NUM_BAR < 1 || NUM_BAR > 32) begin : g_bad_bar
      $error("pci_tgt_ctrl: NUM_BAR must lie in 1..32");
   end
   if (ADDR_W < 8) begin : g_bad_aw
      $error("pci_tgt_ctrl: ADDR_W must be at least 8");
   end

   logic               claim;
   logic [NUM_BAR-1:0] cs_hit;
   logic               cfg_hit;
   logic               post_wr;
   tgt_state_e         state;
   logic               st_data;
   logic               st_stop;
   logic               st_drive;

   pci_tgt_decode #(.NUM_BAR(NUM_BAR), .ADDR_W(ADDR_W)) u_dec (
      .ad        (ad_in),
      .cbe_n     (cbe_in_n),
      .idsel     (idsel_in),
      .bar_base  (bar_base),
      .bar_mask  (bar_mask),
      .bar_is_io (bar_is_io),
      .io_en     (cmd_io_en),
      .mem_en    (cmd_mem_en),
      .claim     (claim),
      .cs_hit    (cs_hit),
      .cfg_hit   (cfg_hit),
      .post_wr   (post_wr)
   );

   pci_tgt_seq #(.NUM_BAR(NUM_BAR)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_in_n (frame_in_n),
      .irdy_in_n  (irdy_in_n),
      .wq_full    (wq_full),
      .claim      (claim),
      .cs_hit     (cs_hit),
      .cfg_hit    (cfg_hit),
      .post_wr    (post_wr),
      .state      (state),
      .cs_sel     (cs_sel),
      .cfg_sel    (cfg_sel)
   );

   // outputs decoded from the single state register
   assign st_data  = (state == ST_DATA);
   assign st_stop  = (state == ST_STOP);
   assign st_drive = st_data || st_stop || (state == ST_TURN);

   assign devsel_out_n = !(st_data || st_stop);
   assign trdy_out_n   = !st_data;
   assign stop_out_n   = !st_stop;
   assign devsel_oe_n  = !st_drive;
   assign trdy_oe_n    = !st_drive;
   assign stop_oe_n    = !st_drive;

endmodule

// File: rtl/pci_tgt_chk.sv
module pci_tgt_chk #(
   parameter int NUM_BAR = 6
) (
   input logic               clk,
   input logic               rst_n,
   input logic               frame_in_n,
   input logic               devsel_out_n,
   input logic               devsel_oe_n,
   input logic               trdy_out_n,
   input logic               trdy_oe_n,
   input logic               stop_out_n,
   input logic               stop_oe_n,
   input logic [NUM_BAR-1:0] cs_sel,
   input logic               cfg_sel
);

   AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cs_sel));                                                       // R4

   AST_CS_WHILE_CLAIMED: assert property (@(posedge clk) disable iff (!rst_n)
      !devsel_out_n |-> ((|cs_sel) || cfg_sel));                               // R4

   AST_CFG_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_sel |-> (cs_sel == '0));                                             // R5

   AST_MEDIUM_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(devsel_out_n) |-> !$past(frame_in_n, 2));                          // R6

   AST_TRDY_STOP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(!trdy_out_n && !stop_out_n));                                          // R9

   AST_DRIVE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
      (!devsel_out_n || !trdy_out_n || !stop_out_n) |->
         (!devsel_oe_n && !trdy_oe_n && !stop_oe_n));                          // R8

   AST_PARK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(devsel_out_n) |-> (!devsel_oe_n && trdy_out_n && stop_out_n));     // R8

   AST_PARK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(devsel_out_n) |=> (devsel_oe_n && trdy_oe_n && stop_oe_n));        // R8

endmodule

bind pci_tgt_ctrl pci_tgt_chk #(.NUM_BAR(NUM_BAR)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .frame_in_n   (frame_in_n),
   .devsel_out_n (devsel_out_n),
   .devsel_oe_n  (devsel_oe_n),
   .trdy_out_n   (trdy_out_n),
   .trdy_oe_n    (trdy_oe_n),
   .stop_out_n   (stop_out_n),
   .stop_oe_n    (stop_oe_n),
   .cs_sel       (cs_sel),
   .cfg_sel      (cfg_sel)
);

// File: tb/sim_pci_tgt_ctrl.sv
`timescale 1ns/100ps
module sim_pci_tgt_ctrl;

   localparam int NB = 6;
   localparam int AW = 32;
   localparam int M_IDLE = 0, M_WAIT = 1, M_DATA = 2, M_STOP = 3, M_TURN = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic          frame_n = 1'b1, irdy_n = 1'b1, idsel = 1'b0;
   logic [AW-1:0] ad = '0;
   logic [3:0]    cbe = 4'hF;
   logic          io_en = 1'b1, mem_en = 1'b1, wq_full = 1'b0;
   logic [NB*AW-1:0] bar_base = {32'h4000_0000, 32'hC000_0000, 32'h0000_2000,
                                 32'h0000_1000, 32'h8000_0000, 32'h8000_0000};
   logic [NB*AW-1:0] bar_mask = {32'hFFFF_F000, 32'hF000_0000, 32'hFFFF_FF00,
                                 32'hFFFF_FF00, 32'hFFF0_0000, 32'hFFFF_0000};
   logic [NB-1:0]    bar_is_io = 6'b001100;

   logic devsel_out_n, devsel_oe_n, trdy_out_n, trdy_oe_n, stop_out_n, stop_oe_n, cfg_sel;
   logic [NB-1:0] cs_sel;

   pci_tgt_ctrl #(.NUM_BAR(NB), .ADDR_W(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .frame_in_n(frame_n), .irdy_in_n(irdy_n),
      .idsel_in(idsel), .ad_in(ad), .cbe_in_n(cbe), .bar_base(bar_base),
      .bar_mask(bar_mask), .bar_is_io(bar_is_io), .cmd_io_en(io_en),
      .cmd_mem_en(mem_en), .wq_full(wq_full), .devsel_out_n(devsel_out_n),
      .devsel_oe_n(devsel_oe_n), .trdy_out_n(trdy_out_n), .trdy_oe_n(trdy_oe_n),
      .stop_out_n(stop_out_n), .stop_oe_n(stop_oe_n), .cs_sel(cs_sel), .cfg_sel(cfg_sel)
   );

   int checks = 0;
   int errors = 0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   // expected decode from R2, R3, R4, R5
   function automatic void exp_decode(input logic [3:0] c, input logic [31:0] a, input logic ids,
                                      input logic ioe, input logic meme,
                                      output logic clm, output logic [NB-1:0] cs,
                                      output logic cf, output logic pw);
      logic io_c, mem_c;
      io_c  = (c == 4'b0010) || (c == 4'b0011);
      mem_c = (c == 4'b0110) || (c == 4'b0111) || (c == 4'b1100) ||
              (c == 4'b1110) || (c == 4'b1111);
      pw    = (c == 4'b0111) || (c == 4'b1111);
      cf    = ((c == 4'b1010) || (c == 4'b1011)) && ids;
      cs    = '0;
      for (int i = NB - 1; i >= 0; i--) begin
         if ((((a ^ bar_base[i*AW +: AW]) & bar_mask[i*AW +: AW]) == '0) &&
             (bar_is_io[i] ? (io_c && ioe) : (mem_c && meme))) begin
            cs    = '0;
            cs[i] = 1'b1;
         end
      end
      clm = cf || (cs != '0);
   endfunction

   // reference sequencer state
   int            m_st = M_IDLE;
   logic          m_fq = 1'b1, m_pw = 1'b0, m_cf = 1'b0;
   logic [NB-1:0] m_cs = '0;

   task automatic model_step();
      logic clm, cf, pw;
      logic [NB-1:0] cs;
      exp_decode(cbe, ad, idsel, io_en, mem_en, clm, cs, cf, pw);
      case (m_st)
         M_IDLE: if (!frame_n && m_fq && clm) begin
            m_st = M_WAIT; m_cs = cs; m_cf = cf; m_pw = pw;
         end
         M_WAIT: m_st = (m_pw && wq_full) ? M_STOP : M_DATA;
         M_DATA: begin
            if (!irdy_n && frame_n)     m_st = M_TURN;
            else if (m_pw && wq_full)   m_st = M_STOP;
         end
         M_STOP: if (frame_n) m_st = M_TURN;
         default: begin m_st = M_IDLE; m_cs = '0; m_cf = 1'b0; m_pw = 1'b0; end
      endcase
      m_fq = frame_n;
   endtask

   // initiator state
   int   ist = 0, gap = 2, beats_left = 0, accepted = 0, full_after = 9, cyc_in = 0, txn = 0;
   bit   t_pw = 0, abort = 0;
   logic s_dev, s_trdy, s_stop;

   task automatic setup_txn();
      logic [3:0] c;
      logic [31:0] a;
      logic clm, cf, pw;
      logic [NB-1:0] cs;
      int r;
      c = 4'h0; a = '0; idsel = 1'b0; io_en = 1'b1; mem_en = 1'b1; beats_left = 1; full_after = 9;
      case (txn)
         0: begin c = 4'b0111; a = 32'h8000_0010; beats_left = 3; full_after = 0; end // R9 retry at first phase
         1: begin c = 4'b0111; a = 32'h8000_0020; beats_left = 4; full_after = 2; end // R9 mid-burst
         2: begin c = 4'b0100; a = 32'h8000_0000; end                              // R2 reserved
         3: begin c = 4'b0110; a = 32'h8000_0000; mem_en = 1'b0; end               // R3 disabled
         4: begin c = 4'b1010; a = 32'h1234_5678; idsel = 1'b1; beats_left = 2; end // R5
         5: begin c = 4'b1011; a = 32'h8000_0000; end                              // R5 no idsel
         6: begin c = 4'b0011; a = 32'h0000_2004; beats_left = 2; full_after = 0; end // R10
         7: begin c = 4'b1111; a = 32'h8008_0000; end                              // R4 upper overlap
         default: begin
            if ($urandom % 2 == 0) begin
               case ($urandom % 7)
                  0: c = 4'b0110; 1: c = 4'b0111; 2: c = 4'b1111; 3: c = 4'b1100;
                  4: c = 4'b1110; 5: c = 4'b0010; default: c = 4'b0011;
               endcase
            end else c = 4'($urandom);
            r = int'($urandom % 7);
            if (r == 6) a = $urandom;
            else a = bar_base[r*AW +: AW] | ($urandom & ~bar_mask[r*AW +: AW]);
            idsel      = 1'($urandom);
            io_en      = ($urandom % 6) != 0;
            mem_en     = ($urandom % 6) != 0;
            beats_left = 1 + int'($urandom % 5);
            full_after = int'($urandom % 7);
         end
      endcase
      exp_decode(c, a, idsel, io_en, mem_en, clm, cs, cf, pw);
      t_pw = clm && pw;
      cbe = c;
      ad  = a;
      txn++;
   endtask

   task automatic check_outputs();
      logic e_dev, e_oe, e_trdy, e_stop;
      e_dev  = !(m_st == M_DATA || m_st == M_STOP);
      e_oe   = !(m_st == M_DATA || m_st == M_STOP || m_st == M_TURN);
      e_trdy = !(m_st == M_DATA);
      e_stop = !(m_st == M_STOP);
      chk(devsel_out_n == e_dev, "R6 R2 R3 devsel", 32'(devsel_out_n), 32'(e_dev));
      chk({devsel_oe_n, trdy_oe_n, stop_oe_n} == {3{e_oe}}, "R8 enables",
          32'({devsel_oe_n, trdy_oe_n, stop_oe_n}), 32'({3{e_oe}}));
      chk(trdy_out_n == e_trdy, "R7 trdy", 32'(trdy_out_n), 32'(e_trdy));
      chk(stop_out_n == e_stop, "R9 R10 stop", 32'(stop_out_n), 32'(e_stop));
      chk(cs_sel == m_cs, "R4 cs_sel", 32'(cs_sel), 32'(m_cs));
      chk(cfg_sel == m_cf, "R5 cfg_sel", 32'(cfg_sel), 32'(m_cf));
   endtask

   initial begin
      void'($urandom(32'd4711));
      repeat (4) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      chk({devsel_out_n, devsel_oe_n, trdy_out_n, trdy_oe_n, stop_out_n, stop_oe_n} == 6'h3F,
          "R1 response lines", 32'({devsel_out_n, devsel_oe_n, trdy_out_n, trdy_oe_n, stop_out_n, stop_oe_n}), 32'h3F);
      chk(cs_sel == '0 && !cfg_sel, "R1 selects", 32'({cfg_sel, cs_sel}), 32'h0);
      rst_n = 1'b1;
      for (int cyc = 0; cyc < 8000; cyc++) begin
         @(negedge clk);
         check_outputs();
         s_dev = devsel_out_n; s_trdy = trdy_out_n; s_stop = stop_out_n;
         if (ist == 0) begin
            frame_n = 1'b1; irdy_n = 1'b1; wq_full = 1'($urandom);
            if (gap > 0) gap--;
            else begin
               setup_txn();
               frame_n = 1'b0; ist = 1; cyc_in = 0; accepted = 0;
            end
         end else begin
            wq_full = t_pw ? (accepted >= full_after) : 1'($urandom);
            if (!s_stop) begin frame_n = 1'b1; irdy_n = 1'b0; end
            else if (s_dev && cyc_in >= 3) begin frame_n = 1'b1; irdy_n = 1'b1; abort = 1; end
            else if (frame_n) irdy_n = 1'b0;
            else begin
               irdy_n  = ($urandom % 4) == 0;
               frame_n = (beats_left == 1 && !irdy_n);
            end
            ad = $urandom; cbe = 4'($urandom);
            cyc_in++;
         end
         @(posedge clk);
         model_step();
         if (ist == 1) begin
            if (abort) begin
               abort = 0; ist = 0; gap = 2 + int'($urandom % 3);
            end else if (!irdy_n && !s_trdy) begin
               accepted++; beats_left--;
               if (frame_n) begin ist = 0; gap = 2 + int'($urandom % 3); end
            end else if (frame_n && !s_stop) begin
               ist = 0; gap = 2 + int'($urandom % 3);
            end
         end
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule